// File: doc/BRIEF.md
# EPP host cycle controller

This block is the host side of an Enhanced Parallel Port. A processor reaches it through a small register window. It uses a one-cycle request strobe with a write flag, a 3-bit offset and a byte of write data. The block answers every request with a single-cycle `done_o` pulse that carries the read byte. Offsets 0 to 2 are plain registers:

- the standard-port data latch at offset 0,
- a status byte at offset 1,
- a control byte at offset 2.

When EPP mode is selected, offset 3 starts an address cycle on the parallel bus and offsets 4 to 7 start data cycles. A data cycle drives the byte and the write line, then pulses the data strobe. It waits for the peripheral to raise its acknowledge line and for that line to drop again. An address cycle does the same but pulses the address strobe.

A watchdog counts clocks from the moment an EPP cycle is accepted. If the cycle has not finished within a time set by a clock frequency parameter and a nanosecond limit (10 µs at 50 MHz gives 500 clocks), the cycle is abandoned. A sticky timeout flag is raised in the status byte, and a read that was cut short returns FFh.

Between EPP cycles the pins behave as a standard or bidirectional port: the strobe-type pins and the bus direction follow the control byte. A control bit that asserts the write line also forces the bus into write mode during an EPP cycle, whatever the requested direction.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: After reset:
  - `pp_wr_n_o`, `pp_dstb_n_o`, `pp_astb_n_o` and `pp_init_n_o` are 1.
  - `pd_oe_o` is 1.
  - Reading offset 1 (status) returns 00h.
  - Reading offset 2 (control) returns 00h.
- R2: A request to offsets 0, 1 or 2 completes with `done_o` one clock after it is accepted.
  - A write to offset 0 stores the byte.
  - A read of offset 0 returns the stored byte while control bit 5 is 0, and returns `pd_i` while bit 5 is 1.
  - A read of offset 2 returns the control byte with bits 4, 6 and 7 as 0.
- R3: When no EPP cycle runs, the pins follow the control byte. A control bit of 1 drives its pin low:
  - bit 0 drives `pp_wr_n_o`;
  - bit 1 drives `pp_dstb_n_o`;
  - bit 2 drives `pp_init_n_o`;
  - bit 3 drives `pp_astb_n_o`.
  
  `pd_oe_o` is the inverse of bit 5, and `pd_o` carries the offset-0 byte.
- R4: In EPP mode, a write to any of offsets 4 to 7 runs a data cycle. While the data strobe is low, `pp_wr_n_o` is 0, `pd_oe_o` is 1 and `pd_o` carries the written byte. The address strobe stays high.
- R5: In EPP mode, a read of any of offsets 4 to 7 runs a data cycle with `pd_oe_o` at 0 and `pp_wr_n_o` at 1. The read returns the `pd_i` byte sampled when the synchronised acknowledge is seen high.
- R6: In EPP mode, offset 3 runs the same cycle as R4 and R5, but `pp_astb_n_o` is pulsed instead of `pp_dstb_n_o`.
- R7: Outside EPP mode, a request to offsets 3 to 7 starts no cycle and pulses no strobe. It completes one clock after acceptance, and a read returns 00h.
- R8: If an EPP cycle has not finished `TIMEOUT_CYCLES` clocks after acceptance (500 at the defaults), it is aborted:
  - `done_o` pulses;
  - status bit 0 is set;
  - an aborted read returns FFh.
  
  This holds whether the stall occurs before or after the acknowledge rises. The flag rises only at the end of a cycle.
- R9: On an abort, both cycle strobes are released, and the pins are back under control-byte rule R3 in the clock that carries `done_o`.
- R10: Status bit 0 stays set until a write to offset 1 with bit 0 at 1. A write with bit 0 at 0 leaves it set. EPP cycles started while it is set run normally.
- R11: While control bit 0 is 1, an EPP cycle keeps `pp_wr_n_o` at 0 and `pd_oe_o` at 1, even for a read.
- R12: Every EPP cycle ends with exactly one `done_o` pulse, and `done_o` is never high while a cycle runs. During an EPP cycle the data and address strobes are never both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| epp_mode_i | input | 1 | 1 selects EPP mode (offsets 3 to 7 live) |
| req_i | input | 1 | One-clock host request, accepted only while idle |
| we_i | input | 1 | 1 for a write request |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Host write data |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 8 | Read result, valid with `done_o` |
| pd_i | input | 8 | Parallel bus input level |
| pd_o | output | 8 | Parallel bus drive value |
| pd_oe_o | output | 1 | Parallel bus output enable |
| pp_ack_i | input | 1 | Peripheral acknowledge (high = transfer taken) |
| pp_wr_n_o | output | 1 | Write line, doubles as the standard-port strobe |
| pp_dstb_n_o | output | 1 | Data strobe, doubles as the auto-feed pin |
| pp_astb_n_o | output | 1 | Address strobe, doubles as the select-in pin |
| pp_init_n_o | output | 1 | Peripheral initialise pin |

## Verification
A cycle state stuck away from idle shows at once: `done_o` never comes back, the strobe stays low, or the bus stays driven during a read. The watchdog still ends the cycle after exactly `TIMEOUT_CYCLES` clocks, so a counter that starts late or wraps shows as a completion count that is off by one or more. A wrong direction latch shows as the wrong `pp_wr_n_o` or `pd_oe_o` level in the very clock the strobe falls. A lost or doubled timeout flag shows up on the next status read.

// File: rtl/epp_pkg.sv
package epp_pkg;

   // host register offsets whose meaning the cycle engine decodes
   localparam logic [2:0] OFS_SPP  = 3'd0;
   localparam logic [2:0] OFS_STAT = 3'd1;
   localparam logic [2:0] OFS_CTRL = 3'd2;
   localparam logic [2:0] OFS_ADDR = 3'd3;

   typedef enum logic [1:0] {
      CY_IDLE,
      CY_SETUP,
      CY_STB,
      CY_HOLD
   } cyc_state_e;

   typedef struct packed {
      logic dir;    // 1: bus released for input
      logic selin;  // 1: address-strobe pin low when idle
      logic init;   // 1: init pin low
      logic afd;    // 1: data-strobe pin low when idle
      logic strb;   // 1: write pin low; forces write mode in a cycle
   } ctrl_t;

   function automatic logic [7:0] ctrl_to_byte(input ctrl_t c);
      return {2'b00, c.dir, 1'b0, c.selin, c.init, c.afd, c.strb};
   endfunction

   function automatic ctrl_t byte_to_ctrl(input logic [7:0] b);
      ctrl_t c;
      c.strb  = b[0];
      c.afd   = b[1];
      c.init  = b[2];
      c.selin = b[3];
      c.dir   = b[5];
      return c;
   endfunction

endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q_o = d_i;
      end else if (STAGES == 1) begin : g_one
         logic s_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni) s_q <= 1'b0;
            else         s_q <= d_i;
         end
         assign q_o = s_q;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni) sh_q <= '0;
            else         sh_q <= {sh_q[STAGES-2:0], d_i};
         end
         assign q_o = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/epp_wdog.sv
module epp_wdog #(
   parameter int unsigned LIMIT = 500
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic expired_o
);

   localparam int unsigned CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)                    cnt_q <= '0;
      else if (!run_i)                cnt_q <= '0;
      else if (cnt_q != CW'(LIMIT))   cnt_q <= cnt_q + 1'b1;
   end

   // high during the last allowed clock; the engine aborts on the next edge
   assign expired_o = run_i && (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/epp_pin_mux.sv
module epp_pin_mux
   import epp_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic          in_cyc_i,
   input  logic          stb_act_i,
   input  logic          cyc_wr_i,
   input  logic          cyc_addr_i,
   input  logic [DW-1:0] cyc_data_i,
   input  ctrl_t         ctrl_i,
   input  logic [DW-1:0] spp_data_i,
   output logic [DW-1:0] pd_o,
   output logic          pd_oe_o,
   output logic          wr_n_o,
   output logic          dstb_n_o,
   output logic          astb_n_o,
   output logic          init_n_o
);

   logic wr_eff;

   // an asserted control strobe bit overrides the cycle direction
   assign wr_eff = cyc_wr_i | ctrl_i.strb;

   always_comb begin
      if (in_cyc_i) begin
         wr_n_o   = ~wr_eff;
         dstb_n_o = ~(stb_act_i & ~cyc_addr_i);
         astb_n_o = ~(stb_act_i & cyc_addr_i);
         pd_oe_o  = wr_eff;
         pd_o     = cyc_data_i;
      end else begin
         wr_n_o   = ~ctrl_i.strb;
         dstb_n_o = ~ctrl_i.afd;
         astb_n_o = ~ctrl_i.selin;
         pd_oe_o  = ~ctrl_i.dir;
         pd_o     = spp_data_i;
      end
   end

   assign init_n_o = ~ctrl_i.init;

endmodule

// File: rtl/epp_cycle_ctrl.sv
module epp_cycle_ctrl
   import epp_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 50_000_000,
   parameter int unsigned TIMEOUT_NS  = 10_000,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DW          = 8,
   parameter int unsigned AW          = 3
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          epp_mode_i,
   input  logic          req_i,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   output logic          done_o,
   output logic [DW-1:0] rdata_o,
   input  logic [DW-1:0] pd_i,
   output logic [DW-1:0] pd_o,
   output logic          pd_oe_o,
   input  logic          pp_ack_i,
   output logic          pp_wr_n_o,
   output logic          pp_dstb_n_o,
   output logic          pp_astb_n_o,
   output logic          pp_init_n_o
);

   localparam int unsigned TIMEOUT_CYCLES = (CLK_HZ / 1000) * TIMEOUT_NS / 1_000_000;

   generate
      if (AW != 3) begin : g_bad_aw
         $error("epp_cycle_ctrl: AW must be 3");
      end
      if (DW != 8) begin : g_bad_dw
         $error("epp_cycle_ctrl: DW must be 8");
      end
      if (TIMEOUT_CYCLES < 4) begin : g_bad_to
         $error("epp_cycle_ctrl: timeout shorter than 4 clocks");
      end
   endgenerate

   cyc_state_e    st_q;
   ctrl_t         ctrl_q;
   logic [DW-1:0] spp_q;
   logic [DW-1:0] cyc_data_q;
   logic [DW-1:0] rdata_q;
   logic          cyc_wr_q;
   logic          cyc_addr_q;
   logic          to_flag_q;
   logic          done_q;
   logic          ack_s;
   logic          in_cyc;
   logic          expired;
   logic          ctrl_strb;
   logic          epp_hit;
   logic [DW-1:0] reg_rd;

   assign in_cyc    = (st_q != CY_IDLE);
   assign ctrl_strb = ctrl_q.strb;
   assign epp_hit   = epp_mode_i && (addr_i >= OFS_ADDR);

   epp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pp_ack_i),
      .q_o   (ack_s)
   );

   epp_wdog #(.LIMIT(TIMEOUT_CYCLES)) u_wdog (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (in_cyc),
      .expired_o(expired)
   );

   epp_pin_mux #(.DW(DW)) u_pins (
      .in_cyc_i  (in_cyc),
      .stb_act_i (st_q == CY_STB),
      .cyc_wr_i  (cyc_wr_q),
      .cyc_addr_i(cyc_addr_q),
      .cyc_data_i(cyc_data_q),
      .ctrl_i    (ctrl_q),
      .spp_data_i(spp_q),
      .pd_o      (pd_o),
      .pd_oe_o   (pd_oe_o),
      .wr_n_o    (pp_wr_n_o),
      .dstb_n_o  (pp_dstb_n_o),
      .astb_n_o  (pp_astb_n_o),
      .init_n_o  (pp_init_n_o)
   );

   always_comb begin
      unique case (addr_i)
         OFS_SPP:  reg_rd = ctrl_q.dir ? pd_i : spp_q;
         OFS_STAT: reg_rd = {{(DW-1){1'b0}}, to_flag_q};
         OFS_CTRL: reg_rd = ctrl_to_byte(ctrl_q);
         default:  reg_rd = '0;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st_q       <= CY_IDLE;
         ctrl_q     <= '0;
         spp_q      <= '0;
         cyc_data_q <= '0;
         rdata_q    <= '0;
         cyc_wr_q   <= 1'b0;
         cyc_addr_q <= 1'b0;
         to_flag_q  <= 1'b0;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            CY_IDLE: begin
               if (req_i && epp_hit) begin
                  st_q       <= CY_SETUP;
                  cyc_wr_q   <= we_i;
                  cyc_addr_q <= (addr_i == OFS_ADDR);
                  cyc_data_q <= wdata_i;
               end else if (req_i) begin
                  done_q  <= 1'b1;
                  rdata_q <= we_i ? '0 : reg_rd;
                  if (we_i) begin
                     unique case (addr_i)
                        OFS_SPP:  spp_q <= wdata_i;
                        OFS_STAT: if (wdata_i[0]) to_flag_q <= 1'b0;
                        OFS_CTRL: ctrl_q <= byte_to_ctrl(wdata_i);
                        default:  ;
                     endcase
                  end
               end
            end
            CY_SETUP: st_q <= CY_STB;
            CY_STB: begin
               if (expired) begin
                  st_q      <= CY_IDLE;
                  done_q    <= 1'b1;
                  to_flag_q <= 1'b1;
                  rdata_q   <= cyc_wr_q ? '0 : '1;
               end else if (ack_s) begin
                  st_q    <= CY_HOLD;
                  rdata_q <= cyc_wr_q ? '0 : pd_i;
               end
            end
            CY_HOLD: begin
               if (expired) begin
                  st_q      <= CY_IDLE;
                  done_q    <= 1'b1;
                  to_flag_q <= 1'b1;
                  rdata_q   <= cyc_wr_q ? '0 : '1;
               end else if (!ack_s) begin
                  st_q   <= CY_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: st_q <= CY_IDLE;
         endcase
      end
   end

   assign done_o  = done_q;
   assign rdata_o = rdata_q;

endmodule

// File: rtl/epp_cycle_ctrl_chk.sv
module epp_cycle_ctrl_chk #(
   parameter int unsigned DW = 8,
   parameter int unsigned AW = 3
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          epp_mode_i,
   input logic          req_i,
   input logic [AW-1:0] addr_i,
   input logic          done_o,
   input logic [DW-1:0] rdata_o,
   input logic          pd_oe_o,
   input logic          pp_wr_n_o,
   input logic          pp_dstb_n_o,
   input logic          pp_astb_n_o,
   input logic          in_cyc_i,
   input logic          ctrl_strb_i,
   input logic          to_flag_i,
   input logic          cyc_wr_i
);

   // R12
   one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_cyc_i |-> (pp_dstb_n_o || pp_astb_n_o));

   // R12
   no_done_in_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_cyc_i |-> !done_o);

   // R12
   cycle_end_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(in_cyc_i) |-> done_o);

   // R7
   no_epp_quick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && !in_cyc_i && !epp_mode_i) |=> (done_o && !in_cyc_i));

   // R8
   flag_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(to_flag_i) |-> ($past(in_cyc_i) && done_o));

   // R8
   abort_read_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(to_flag_i) && !cyc_wr_i) |-> (rdata_o == '1));

   // R9
   abort_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(to_flag_i) |-> !in_cyc_i);

   // R11
   strobe_override_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_cyc_i && ctrl_strb_i) |-> (!pp_wr_n_o && pd_oe_o));

   // R5
   read_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_cyc_i && !cyc_wr_i && !ctrl_strb_i) |-> (!pd_oe_o && pp_wr_n_o));

   wire unused_ok = &{1'b0, addr_i};

endmodule

bind epp_cycle_ctrl epp_cycle_ctrl_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .epp_mode_i (epp_mode_i),
   .req_i      (req_i),
   .addr_i     (addr_i),
   .done_o     (done_o),
   .rdata_o    (rdata_o),
   .pd_oe_o    (pd_oe_o),
   .pp_wr_n_o  (pp_wr_n_o),
   .pp_dstb_n_o(pp_dstb_n_o),
   .pp_astb_n_o(pp_astb_n_o),
   .in_cyc_i   (in_cyc),
   .ctrl_strb_i(ctrl_strb),
   .to_flag_i  (to_flag_q),
   .cyc_wr_i   (cyc_wr_q)
);

// File: tb/epp_cycle_ctrl_tb.sv
module epp_cycle_ctrl_tb;

   localparam int TO_CYC   = 500;   // 10 us at 50 MHz
   localparam int RESP_DLY = 3;
   localparam int NVEC     = 11;
   // {we, addr[2:0], wdata[7:0], pd_i[7:0], expected rdata[7:0]}
   localparam logic [27:0] VEC [NVEC] = '{
      {1'b1, 3'd4, 8'hA5, 8'h00, 8'h00},
      {1'b1, 3'd5, 8'h3C, 8'h00, 8'h00},
      {1'b1, 3'd6, 8'hC3, 8'h00, 8'h00},
      {1'b1, 3'd7, 8'h0F, 8'h00, 8'h00},
      {1'b0, 3'd4, 8'h00, 8'h5A, 8'h5A},
      {1'b0, 3'd6, 8'h00, 8'h96, 8'h96},
      {1'b0, 3'd7, 8'h00, 8'hE1, 8'hE1},
      {1'b1, 3'd3, 8'h42, 8'h00, 8'h00},
      {1'b0, 3'd3, 8'h00, 8'h77, 8'h77},
      {1'b1, 3'd0, 8'h81, 8'h00, 8'h00},
      {1'b0, 3'd0, 8'h00, 8'h3B, 8'h81}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       epp_mode = 1'b1;
   logic       req = 1'b0;
   logic       we = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic       done;
   logic [7:0] rdata;
   logic [7:0] pdin = '0;
   logic [7:0] pd_o;
   logic       pd_oe;
   logic       ack;
   logic       wr_n, dstb_n, astb_n, init_n;

   always #10 clk = ~clk;

   epp_cycle_ctrl u_dut (
      .clk_i(clk), .rst_ni(rst_n), .epp_mode_i(epp_mode),
      .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
      .done_o(done), .rdata_o(rdata),
      .pd_i(pdin), .pd_o(pd_o), .pd_oe_o(pd_oe),
      .pp_ack_i(ack), .pp_wr_n_o(wr_n), .pp_dstb_n_o(dstb_n),
      .pp_astb_n_o(astb_n), .pp_init_n_o(init_n)
   );

   // peripheral model
   logic       resp_en = 1'b0;
   logic       stuck = 1'b0;
   logic [3:0] dly;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack <= 1'b0;
         dly <= '0;
      end else if (resp_en && (!dstb_n || !astb_n) && !ack) begin
         if (dly == 4'(RESP_DLY)) begin ack <= 1'b1; dly <= '0; end
         else dly <= dly + 1'b1;
      end else if (ack && dstb_n && astb_n && !stuck) begin
         ack <= 1'b0;
      end
   end

   // strobe monitor
   logic       mon_arm = 1'b0;
   logic       d_seen, a_seen, both_seen;
   logic       m_wr_n, m_oe;
   logic [7:0] m_pd;
   always @(negedge clk) begin
      if (mon_arm) begin
         if (!dstb_n || !astb_n) begin
            m_wr_n = wr_n;
            m_oe   = pd_oe;
            m_pd   = pd_o;
         end
         if (!dstb_n) d_seen = 1'b1;
         if (!astb_n) a_seen = 1'b1;
         if (!dstb_n && !astb_n) both_seen = 1'b1;
      end
   end

   int n_chk = 0;
   int n_err = 0;

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic mon_clear();
      d_seen = 1'b0; a_seen = 1'b0; both_seen = 1'b0;
      m_wr_n = 1'b1; m_oe = 1'b0; m_pd = '0;
   endtask

   task automatic acc(input logic w, input logic [2:0] a, input logic [7:0] d,
                      output logic [7:0] r, output int n);
      @(negedge clk);
      req = 1'b1; we = w; addr = a; wdata = d;
      @(negedge clk);
      req = 1'b0;
      n = 1;
      while (!done && n < 2000) begin
         @(negedge clk);
         n++;
      end
      r = rdata;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not finish");
      finish_run();
   end

   initial begin
      logic [7:0] r;
      int n;
      mon_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 pins", {wr_n, dstb_n, astb_n, init_n, pd_oe}, 5'b11111);
      acc(1'b0, 3'd1, 8'h00, r, n);
      check("R1 status", r, 8'h00);
      acc(1'b0, 3'd2, 8'h00, r, n);
      check("R1 control", r, 8'h00);

      // R3 idle pins follow control
      acc(1'b1, 3'd2, 8'h0F, r, n);
      @(negedge clk);
      check("R3 pins low", {wr_n, dstb_n, astb_n, init_n, pd_oe}, 5'b00001);
      acc(1'b0, 3'd2, 8'h00, r, n);
      check("R2 control readback", r, 8'h0F);
      acc(1'b1, 3'd2, 8'hFF, r, n);
      acc(1'b0, 3'd2, 8'h00, r, n);
      check("R2 control unused bits", r, 8'h2F);
      acc(1'b1, 3'd2, 8'h20, r, n);
      @(negedge clk);
      check("R3 bus released", pd_oe, 1'b0);
      pdin = 8'h3B;
      acc(1'b0, 3'd0, 8'h00, r, n);
      check("R2 data reads bus in input mode", r, 8'h3B);
      acc(1'b1, 3'd2, 8'h00, r, n);
      check("R2 register access latency", n, 1);
      @(negedge clk);
      check("R12 done single clock", done, 1'b0);

      // vector table walk in EPP mode
      resp_en = 1'b1;
      mon_arm = 1'b1;
      for (int i = 0; i < NVEC; i++) begin
         logic       vw;
         logic [2:0] va;
         logic [7:0] vd, vp, ve;
         string      rq;
         {vw, va, vd, vp, ve} = VEC[i];
         pdin = vp;
         mon_clear();
         acc(vw, va, vd, r, n);
         rq = (va == 3'd3) ? "R6" : (va < 3'd3) ? "R2" : vw ? "R4" : "R5";
         if (!vw) check(rq, r, ve);
         if (va >= 3'd3) begin
            check({rq, " strobe line"}, {d_seen, a_seen}, (va == 3'd3) ? 2'b01 : 2'b10);
            check({rq, " direction"}, {m_wr_n, m_oe}, vw ? 2'b01 : 2'b10);
            if (vw) check({rq, " bus data"}, m_pd, vd);
            check("R12 strobes exclusive", both_seen, 1'b0);
            check({rq, " finished before timeout"}, (n < 100), 1'b1);
         end else begin
            check("R2 no strobe", {d_seen, a_seen}, 2'b00);
         end
      end

      // R7 offsets 3..7 outside EPP mode
      epp_mode = 1'b0;
      mon_clear();
      acc(1'b1, 3'd5, 8'h99, r, n);
      check("R7 latency", n, 1);
      pdin = 8'hAB;
      acc(1'b0, 3'd6, 8'h00, r, n);
      check("R7 read zero", r, 8'h00);
      check("R7 no strobe", {d_seen, a_seen}, 2'b00);
      epp_mode = 1'b1;

      // R11 strobe bit overrides read direction
      acc(1'b1, 3'd2, 8'h01, r, n);
      mon_clear();
      pdin = 8'h44;
      acc(1'b0, 3'd4, 8'h00, r, n);
      check("R11 forced write mode", {m_wr_n, m_oe}, 2'b01);
      check("R11 read value", r, 8'h44);
      acc(1'b1, 3'd2, 8'h00, r, n);

      // R8 / R9 timeout before acknowledge
      resp_en = 1'b0;
      acc(1'b1, 3'd4, 8'h11, r, n);
      check("R8 write abort time", n, TO_CYC + 1);
      check("R9 strobes released", {wr_n, dstb_n, astb_n, pd_oe}, 4'b1111);
      acc(1'b0, 3'd1, 8'h00, r, n);
      check("R8 status flag", r, 8'h01);
      acc(1'b0, 3'd5, 8'h00, r, n);
      check("R8 read abort time", n, TO_CYC + 1);
      check("R8 read abort value", r, 8'hFF);

      // R8 stall after acknowledge rises
      resp_en = 1'b1;
      stuck = 1'b1;
      pdin = 8'h12;
      acc(1'b0, 3'd6, 8'h00, r, n);
      check("R8 hold-phase abort time", n, TO_CYC + 1);
      check("R8 hold-phase abort value", r, 8'hFF);
      stuck = 1'b0;
      repeat (4) @(negedge clk);

      // R10 sticky flag
      acc(1'b1, 3'd1, 8'h00, r, n);
      acc(1'b0, 3'd1, 8'h00, r, n);
      check("R10 write 0 keeps flag", r, 8'h01);
      mon_clear();
      acc(1'b1, 3'd7, 8'h5C, r, n);
      check("R10 cycle runs with flag set", (n < 100), 1'b1);
      check("R10 cycle data", m_pd, 8'h5C);
      acc(1'b0, 3'd1, 8'h00, r, n);
      check("R10 flag still set", r, 8'h01);
      acc(1'b1, 3'd1, 8'h01, r, n);
      acc(1'b0, 3'd1, 8'h00, r, n);
      check("R10 flag cleared", r, 8'h00);

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule